// File: doc/BRIEF.md
# Flash Write-Command Decoder with Unlock Bypass

This block is the synchronous front end of a NOR-style flash device's command interface. It watches bus write cycles, each an address and a data byte, and turns the accepted sequences into program requests and mode changes. In normal mode a program needs a two-cycle unlock prefix, a setup cycle and then the address/data cycle. A bypass mode drops the prefix, so a program takes two writes. Bypass mode accepts only a few commands and has its own exit sequence.

Each accepted program word produces a one-cycle `prog_req` pulse that carries the target address and data. After a single-word program, or after a confirmed buffered load, the block reports a busy programming phase that lasts `PROG_LAT` cycles. A write that the current state does not accept is dropped and flagged with a one-cycle `rej` pulse. The `accel` input stands in for the high-voltage accelerate pin and is treated as an ordinary logic level. While it is high the block is in bypass mode without any unlock sequence.

Top module: `flash_cmd_dec`

## Requirements
- R1: After reset `mode` is 0 (read), and `prog_req` and `rej` are 0. The `mode` encoding is 0 = read, 1 = bypass, 2 = programming.
- R2: In read mode the writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data D at address A give a `prog_req` pulse with `prog_addr`=A and `prog_data`=D. From the next cycle `mode` is 2 for `PROG_LAT` cycles and then returns to 0.
- R3: In read mode the writes 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 put `mode` at 1.
- R4: In bypass mode 0xA0 at any address, followed by D at A, gives a `prog_req` with A and D. After the programming phase `mode` goes back to 1.
- R5: In bypass mode, at the start of a command, any data other than 0xA0, 0x25 or 0x90 is rejected with a `rej` pulse. This includes 0xAA and 0xF0. `mode` stays 1.
- R6: In bypass mode, 0x90 followed by 0x00 returns `mode` to 0. If anything other than 0x00 follows the 0x90, that write is rejected and `mode` stays 1.
- R7: In normal mode, a wrong address or wrong data within the unlock or setup sequence aborts it. The block then gives a `rej` pulse, issues no `prog_req`, and `mode` stays 0. A later correct sequence is accepted.
- R8: In normal mode, 0xF0 at any step of a sequence silently returns the decoder to idle, with no `rej`. A lone 0xA0 after that is rejected.
- R9: Buffered programming works as follows:
  - In normal mode the command 0x25 follows the unlock prefix. In bypass mode 0x25 is issued directly.
  - The next write is N-1, where N-1 is less than `WB_MAX`.
  - Each of the next N writes gives a `prog_req`.
  - A confirm of 0x29 then starts the programming phase (`mode` 2).
- R10: Any confirm other than 0x29 is rejected and locks the decoder. While locked, every write is rejected, including 0x90 and 0x00. Only the three writes 0xAA@0x555, 0x55@0x2AA, 0xF0@0x555 clear the lock. The decoder then returns to the mode it had before.
- R11: While `accel` is high and the block is not programming, `mode` is 1. Once `accel` goes low and any programming phase has ended, `mode` returns to 0 (unless bypass was entered by command).
- R12: While `mode` is 2, writes are rejected and give no `prog_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| accel | input | 1 | Accelerate level; high forces bypass mode |
| mode | output | 2 | 0 read, 1 bypass, 2 programming |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | AW | Address of the program request |
| prog_data | output | 8 | Data of the program request |
| rej | output | 1 | One-cycle flag for a write that was not accepted |

## Verification
The assertions assume the following about the inputs:
- `wr_en` is a clean one-cycle-per-write strobe.
- `wr_addr` and `wr_data` are stable in the cycle it is sampled.
- `PROG_LAT` is at least 2, so that the programming phase spans more than one cycle.

The stimulus keeps within these assumptions in three ways. It drives every write on the falling edge and holds it for exactly one rising edge, with an idle cycle between writes. It holds `accel` steady across command sequences except in the deliberate release during a programming phase. It reads the one-cycle pulses immediately after the edge that launches them.

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec #(
  parameter int AW       = 12,
  parameter int PROG_LAT = 4,
  parameter int WB_MAX   = 16,
  parameter int UNLK_A   = 'h555,
  parameter int UNLK_B   = 'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          accel,
  output logic [1:0]    mode,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          rej
);
  localparam int CW  = $clog2(PROG_LAT + 1);
  localparam int WBW = $clog2(WB_MAX);

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PSET, S_WCNT, S_WDAT, S_WCONF,
    S_BRST, S_LOCK, S_LU1, S_LU2, S_BUSY
  } st_t;

  st_t            st;
  logic           byp_cmd, byp_acc;
  logic [CW-1:0]  cnt;
  logic [WBW-1:0] wbn;

  wire byp  = byp_cmd | byp_acc;
  wire at_a = wr_addr == AW'(UNLK_A);
  wire at_b = wr_addr == AW'(UNLK_B);

  assign mode = (st == S_BUSY) ? 2'd2 : (byp ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      byp_cmd   <= 1'b0;
      byp_acc   <= 1'b0;
      cnt       <= '0;
      wbn       <= '0;
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      rej       <= 1'b0;
    end else begin
      prog_req <= 1'b0;
      rej      <= 1'b0;
      if (accel) byp_acc <= 1'b1;
      else if (st == S_IDLE) byp_acc <= 1'b0;

      if (st == S_BUSY) begin
        if (cnt == '0) st <= S_IDLE;
        else cnt <= cnt - 1'b1;
        if (wr_en) rej <= 1'b1;
      end else if (wr_en) begin
        case (st)
          S_IDLE:
            if (byp) begin
              if (wr_data == 8'hA0) st <= S_PSET;
              else if (wr_data == 8'h25) st <= S_WCNT;
              else if (wr_data == 8'h90) st <= S_BRST;
              else rej <= 1'b1;
            end else begin
              if (wr_data == 8'hAA && at_a) st <= S_U1;
              else if (wr_data != 8'hF0) rej <= 1'b1;
            end
          S_U1: begin
            st <= S_IDLE;
            if (wr_data == 8'h55 && at_b) st <= S_U2;
            else if (wr_data != 8'hF0) rej <= 1'b1;
          end
          S_U2: begin
            st <= S_IDLE;
            if (wr_data == 8'hA0 && at_a) st <= S_PSET;
            else if (wr_data == 8'h20 && at_a) byp_cmd <= 1'b1;
            else if (wr_data == 8'h25) st <= S_WCNT;
            else if (wr_data != 8'hF0) rej <= 1'b1;
          end
          S_PSET: begin
            prog_req  <= 1'b1;
            prog_addr <= wr_addr;
            prog_data <= wr_data;
            cnt       <= CW'(PROG_LAT - 1);
            st        <= S_BUSY;
          end
          S_WCNT:
            if (int'(wr_data) < WB_MAX) begin
              wbn <= wr_data[WBW-1:0];
              st  <= S_WDAT;
            end else begin
              rej <= 1'b1;
              st  <= S_IDLE;
            end
          S_WDAT: begin
            prog_req  <= 1'b1;
            prog_addr <= wr_addr;
            prog_data <= wr_data;
            if (wbn == '0) st <= S_WCONF;
            else wbn <= wbn - 1'b1;
          end
          S_WCONF:
            if (wr_data == 8'h29) begin
              cnt <= CW'(PROG_LAT - 1);
              st  <= S_BUSY;
            end else begin
              rej <= 1'b1;
              st  <= S_LOCK;
            end
          S_BRST: begin
            st <= S_IDLE;
            if (wr_data == 8'h00) byp_cmd <= 1'b0;
            else rej <= 1'b1;
          end
          S_LOCK:
            if (wr_data == 8'hAA && at_a) st <= S_LU1;
            else rej <= 1'b1;
          S_LU1:
            if (wr_data == 8'h55 && at_b) st <= S_LU2;
            else begin
              rej <= 1'b1;
              st  <= S_LOCK;
            end
          S_LU2:
            if (wr_data == 8'hF0 && at_a) st <= S_IDLE;
            else begin
              rej <= 1'b1;
              st  <= S_LOCK;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  // R2
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == 2'd2) |=> mode == 2'd2);

  // R2
  req_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(wr_en) && prog_addr == $past(wr_addr) && prog_data == $past(wr_data));

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && rej));

  // R11
  accel_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accel) && mode != 2'd2 |-> mode == 2'd1);

  // R12
  busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == 2'd2) && mode == 2'd2 |-> !prog_req);
endmodule

// File: tb/sim_flash_cmd_dec.sv
module sim_flash_cmd_dec;
  localparam int CLK_PER = 10;
  localparam int AW = 12;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, accel = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode;
  logic prog_req, rej;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data;
  int total = 0, bad = 0;
  logic pr, rj;

  flash_cmd_dec #(.AW(AW), .PROG_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accel(accel), .mode(mode), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .rej(rej));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d[7:0];
    @(posedge clk); #1;
    pr = prog_req; rj = rej;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic unlock();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  task automatic t_reset();
    chk("R1 mode", int'(mode), 0);
    chk("R1 prog_req", int'(prog_req), 0);
    chk("R1 rej", int'(rej), 0);
  endtask

  task automatic t_normal_prog();
    unlock(); wr('h555, 'hA0);
    chk("R2 no early req", int'(pr), 0);
    wr('h123, 'h5A);
    chk("R2 req", int'(pr), 1);
    chk("R2 addr", int'(prog_addr), 'h123);
    chk("R2 data", int'(prog_data), 'h5A);
    chk("R2 busy", int'(mode), 2);
    wr('h123, 'h11);
    chk("R12 rej while busy", int'(rj), 1);
    chk("R12 no req while busy", int'(pr), 0);
    idle(LAT + 2);
    chk("R2 back to read", int'(mode), 0);
  endtask

  task automatic t_normal_abort();
    unlock(); wr('h555, 'h77);
    chk("R7 bad cmd rej", int'(rj), 1);
    chk("R7 mode", int'(mode), 0);
    wr('h555, 'hAA); wr('h2AB, 'h55);
    chk("R7 bad addr rej", int'(rj), 1);
    wr('h100, 'h33);
    chk("R7 no req", int'(pr), 0);
    unlock(); wr('h555, 'hA0); wr('h200, 'hC3);
    chk("R7 later seq ok", int'(pr), 1);
    idle(LAT + 2);
  endtask

  task automatic t_f0_reset();
    unlock(); wr('h000, 'hF0);
    chk("R8 f0 silent", int'(rj), 0);
    wr('h555, 'hA0);
    chk("R8 lone A0 rej", int'(rj), 1);
  endtask

  task automatic t_bypass();
    unlock(); wr('h555, 'h20);
    chk("R3 bypass", int'(mode), 1);
    wr('h000, 'hA0); wr('h321, 'h99);
    chk("R4 req", int'(pr), 1);
    chk("R4 addr", int'(prog_addr), 'h321);
    chk("R4 data", int'(prog_data), 'h99);
    idle(LAT + 2);
    chk("R4 back to bypass", int'(mode), 1);
    wr('h555, 'hAA);
    chk("R5 AA rej", int'(rj), 1);
    wr('h555, 'hF0);
    chk("R5 F0 rej", int'(rj), 1);
    chk("R5 mode", int'(mode), 1);
    wr('h400, 'h90); wr('h000, 'h55);
    chk("R6 bad exit rej", int'(rj), 1);
    chk("R6 still bypass", int'(mode), 1);
    wr('h400, 'h90); wr('h000, 'h00);
    chk("R6 exit", int'(mode), 0);
  endtask

  task automatic t_wbuf_normal();
    unlock(); wr('h300, 'h25); wr('h300, 2);
    for (int i = 0; i < 3; i++) begin
      wr('h300 + i, 'h40 + i);
      chk("R9 word req", int'(pr), 1);
      chk("R9 word data", int'(prog_data), 'h40 + i);
    end
    wr('h300, 'h29);
    chk("R9 confirm busy", int'(mode), 2);
    idle(LAT + 2);
    chk("R9 done", int'(mode), 0);
  endtask

  task automatic t_wbuf_lock();
    unlock(); wr('h555, 'h20);
    wr('h300, 'h25); wr('h300, 0); wr('h300, 'h12);
    wr('h300, 'h33);
    chk("R10 bad confirm rej", int'(rj), 1);
    wr('h400, 'h90);
    chk("R10 90 locked", int'(rj), 1);
    wr('h000, 'h00);
    chk("R10 00 locked", int'(rj), 1);
    chk("R10 mode bypass", int'(mode), 1);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hF0);
    chk("R10 unlock ok", int'(rj), 0);
    wr('h000, 'hA0); wr('h010, 'h66);
    chk("R10 back in bypass", int'(pr), 1);
    idle(LAT + 2);
    wr('h400, 'h90); wr('h000, 'h00);
    chk("R10 exit", int'(mode), 0);
  endtask

  task automatic t_accel();
    @(negedge clk); accel = 1;
    idle(2);
    chk("R11 accel bypass", int'(mode), 1);
    wr('h000, 'hA0); wr('h050, 'h77);
    chk("R11 short prog", int'(pr), 1);
    @(negedge clk); accel = 0;
    idle(LAT + 4);
    chk("R11 release read", int'(mode), 0);
  endtask

  initial begin
    #(CLK_PER * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(1);
    t_reset();
    t_normal_prog();
    t_normal_abort();
    t_f0_reset();
    t_bypass();
    t_wbuf_normal();
    t_wbuf_lock();
    t_accel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule